// File: doc/BRIEF.md
# Strap-configured management processor slave port

This block is a synchronous slave port through which an external management processor reads and writes a small internal register space. Five strap inputs are captured as reset ends. They set the processor clock ratio, the byte order, the meaning of the read/write line, the width of the processor data bus and whether ready leads the read data by one bus clock. One port can therefore serve processor families with different bus conventions.

A bus cycle starts when address strobe and chip select are both low on a bus-clock tick. The port runs a three-step sequence: capture, access, complete. It gives an active-low ready, always answers with a 16-bit bus-size indication, and then returns to idle. A 16-word register file stands in for the internal space. Bit 0 of word 0 sets the polarity of the single interrupt output. The asynchronous reset input is turned into a reset output whose deassertion is synchronous to the clock. That reset output also drives all internal logic.

Top module: `mgmt_bus_port`

## Requirements
- R1: The strap bits are captured on the last clock edge at which the reset output is still high. Later changes on the strap inputs have no effect until the next reset.
- R2: The reset output goes high at once when `rst_async_n` is low, and falls on the second clock edge after `rst_async_n` rises. While reset is high, `rdy_n` is high, `bus_rdata_oe` is low and `irq` is high.
- R3: A cycle starts only when `ads_n` and `cs_n` are both low at a bus-clock tick. Either one low on its own produces no ready and writes nothing.
- R4: With strap bit 2 low, `rwc` high means read and low means write. With strap bit 2 high, `rwc` low means read and high means write.
- R5: With strap bit 4 high, ready and the read data are valid together for exactly one bus clock. In 1X mode this window is the clock that follows the second edge, counting the edge that captured the strobe.
- R6: With strap bit 4 low, ready is low for one bus clock directly after the strobe edge. The read data is valid for the following bus clock, and ready is high during it.
- R7: With strap bit 0 high (2X clock), the port advances on every second clock, so each ready or data window lasts two clocks. With bit 0 low it advances on every clock.
- R8: With strap bit 1 high (big endian), the two bytes of a 16-bit word are swapped between the bus and the register file in both directions. With bit 1 low they pass straight through. Register contents are not cleared by reset.
- R9: With strap bit 3 high (32-bit bus), the word travels on bits 31:16 when `bus_addr[1]` is 1 and on bits 15:0 otherwise. With bit 3 low it always travels on bits 15:0. The unused lanes of `bus_rdata` read as zero.
- R10: `bs16_n` is low on every cycle.
- R11: Bit 0 of register word 0 sets the interrupt polarity. When it is 0 (the reset value), `irq` is the inverse of `irq_req`. When it is 1, `irq` follows `irq_req`.
- R12: While `cs_n` is high, `rdy_n` is high and `bus_rdata_oe` is low.
- R13: Word addresses 0 to 15 reach the register file, and a write followed by a read returns the written word. An address with any bit above bit 4 set is a miss: a write to it is ignored and a read of it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_async_n | input | 1 | Asynchronous reset, active low |
| strap_cfg | input | 5 | Strap inputs captured at the end of reset |
| irq_req | input | 1 | Internal interrupt request, active high |
| bus_addr | input | 11 | Word address, bits 11 down to 1 |
| ads_n | input | 1 | Address strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| rwc | input | 1 | Read/write control, meaning set by strap bit 2 |
| bus_wdata | input | 32 | Write data from the processor |
| bus_rdata | output | 32 | Read data to the processor, zero when not enabled |
| bus_rdata_oe | output | 1 | Read data output enable |
| rdy_n | output | 1 | Ready, active low, open-drain style |
| bs16_n | output | 1 | Bus size 16 response, active low |
| irq | output | 1 | Interrupt with programmable polarity |
| rst_out | output | 1 | Reset output with synchronous deassertion, active high |

## Verification
Two functions can fall in the same cycle. One is the withdrawal of chip select while a cycle is in progress. The other is the point at which ready or the data enable would be asserted. The bench provokes this by dropping `cs_n` on the clock right after the strobe is captured, and checks that neither `rdy_n` nor `bus_rdata_oe` becomes active afterwards. A later normal read must still return the stored word. In 2X mode the strobe tick can land on either phase of the divider. For that reason the bench holds the strobe for a full bus clock and judges the lengths of the ready and data windows, not their absolute positions.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

  // Strap fields, most significant strap first (bit 4 down to bit 0)
  typedef struct packed {
    logic rdy_with_data;  // 1: ready together with data, 0: ready one bus clock early
    logic wide_bus;       // 1: 32-bit processor bus
    logic rwc_low_read;   // 1: rwc low means read
    logic big_endian;     // 1: swap bytes
    logic clk_double;     // 1: clock runs at twice the bus clock
  } strap_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACCESS = 2'd1,
    ST_DONE = 2'd2
  } bus_st_t;

endpackage

// File: rtl/mbp_reset_sync.sv
module mbp_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst = ~chain[STAGES-1];
endmodule

// File: rtl/mbp_regfile.sv
module mbp_regfile #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_pol
);
  logic [DATA_W-1:0] mem [WORDS];

  // Plain synchronous RAM: registered read, no reset on contents
  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    if (rd_en) rdata <= mem[idx];
  end

  // Shadow of word 0 bit 0 for the interrupt polarity
  always_ff @(posedge clk) begin
    if (rst)                         irq_pol <= 1'b0;
    else if (wr_en && idx == '0)     irq_pol <= wdata[0];
  end
endmodule

// File: rtl/mbp_bus_fsm.sv
module mbp_bus_fsm
  import mbp_pkg::*;
#(
  parameter int ADDR_HI = 11,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 4,
  localparam int BUS_W  = 2 * DATA_W,
  localparam int HALF   = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  strap_t            strap_in,
  input  logic [ADDR_HI:1]  addr,
  input  logic              ads_n,
  input  logic              cs_n,
  input  logic              rwc,
  input  logic [BUS_W-1:0]  wdata_bus,
  output logic [BUS_W-1:0]  rdata_bus,
  output logic              oe,
  output logic              rdy_n,
  output logic [IDX_W-1:0]  idx,
  output logic              rd_en,
  output logic              wr_en,
  output logic [DATA_W-1:0] wword,
  input  logic [DATA_W-1:0] rword,
  output strap_t            strap_q,
  output bus_st_t           state,
  output logic              ce
);
  logic              phase;
  logic [ADDR_HI:1]  addr_q;
  logic              rd_q, rdy_q, oe_q;
  logic              start, hit, lane_in_hi, lane_q_hi;
  logic [DATA_W-1:0] wsel, word_out;

  // Straps follow the input while reset is high, then freeze
  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_in;
  end

  // Bus clock tick: every clock in 1X, every other clock in 2X
  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end
  assign ce = ~strap_q.clk_double | phase;

  assign start      = ~ads_n & ~cs_n;
  assign lane_in_hi = strap_q.wide_bus & addr[1];
  assign lane_q_hi  = strap_q.wide_bus & addr_q[1];
  assign wsel       = lane_in_hi ? wdata_bus[BUS_W-1:DATA_W] : wdata_bus[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      rd_q   <= 1'b0;
      rdy_q  <= 1'b1;
      oe_q   <= 1'b0;
      wword  <= '0;
    end else if (ce) begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_ACCESS;
          addr_q <= addr;
          rd_q   <= rwc ^ strap_q.rwc_low_read;
          wword  <= strap_q.big_endian ? {wsel[HALF-1:0], wsel[DATA_W-1:HALF]} : wsel;
          rdy_q  <= strap_q.rdy_with_data;
        end
        ST_ACCESS: begin
          state <= ST_DONE;
          oe_q  <= rd_q;
          rdy_q <= ~strap_q.rdy_with_data;
        end
        default: begin
          state <= ST_IDLE;
          oe_q  <= 1'b0;
          rdy_q <= 1'b1;
        end
      endcase
    end
  end

  assign hit   = (addr_q[ADDR_HI:IDX_W+1] == '0);
  assign idx   = addr_q[IDX_W:1];
  assign rd_en = ce && (state == ST_ACCESS) && rd_q;
  assign wr_en = ce && (state == ST_ACCESS) && !rd_q && hit;

  always_comb begin
    word_out = '0;
    if (hit) word_out = strap_q.big_endian ? {rword[HALF-1:0], rword[DATA_W-1:HALF]} : rword;
  end

  always_comb begin
    rdata_bus = '0;
    if (oe) begin
      if (lane_q_hi) rdata_bus[BUS_W-1:DATA_W] = word_out;
      else           rdata_bus[DATA_W-1:0]     = word_out;
    end
  end

  assign oe    = oe_q & ~cs_n;
  assign rdy_n = rdy_q | cs_n;
endmodule

// File: rtl/mgmt_bus_port.sv
module mgmt_bus_port
  import mbp_pkg::*;
#(
  parameter int ADDR_HI   = 11,
  parameter int DATA_W    = 16,
  parameter int REG_WORDS = 16,
  parameter int RST_STAGES = 2,
  localparam int BUS_W    = 2 * DATA_W,
  localparam int IDX_W    = $clog2(REG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_async_n,
  input  logic [4:0]        strap_cfg,
  input  logic              irq_req,
  input  logic [ADDR_HI:1]  bus_addr,
  input  logic              ads_n,
  input  logic              cs_n,
  input  logic              rwc,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rdata_oe,
  output logic              rdy_n,
  output logic              bs16_n,
  output logic              irq,
  output logic              rst_out
);
  strap_t            strap_q;
  bus_st_t           state;
  logic              ce, rd_en, wr_en, irq_pol;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] wword, rword;
  logic [4:0]        strap_bits;
  logic [1:0]        st_bits;

  mbp_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_async_n), .rst(rst_out)
  );

  mbp_bus_fsm #(.ADDR_HI(ADDR_HI), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst(rst_out), .strap_in(strap_t'(strap_cfg)),
    .addr(bus_addr), .ads_n(ads_n), .cs_n(cs_n), .rwc(rwc),
    .wdata_bus(bus_wdata), .rdata_bus(bus_rdata), .oe(bus_rdata_oe), .rdy_n(rdy_n),
    .idx(idx), .rd_en(rd_en), .wr_en(wr_en), .wword(wword), .rword(rword),
    .strap_q(strap_q), .state(state), .ce(ce)
  );

  mbp_regfile #(.DATA_W(DATA_W), .WORDS(REG_WORDS)) u_regs (
    .clk(clk), .rst(rst_out), .rd_en(rd_en), .wr_en(wr_en), .idx(idx),
    .wdata(wword), .rdata(rword), .irq_pol(irq_pol)
  );

  always_ff @(posedge clk) begin
    if (rst_out) irq <= 1'b1;
    else         irq <= irq_pol ? irq_req : ~irq_req;
  end

  assign bs16_n     = 1'b0;
  assign strap_bits = strap_q;
  assign st_bits    = state;
endmodule

// File: rtl/mbp_checker.sv
module mbp_checker (
  input logic       clk,
  input logic       rst_async_n,
  input logic       rst_out,
  input logic [4:0] strap_bits,
  input logic [1:0] st_bits,
  input logic       ce,
  input logic       ads_n,
  input logic       cs_n,
  input logic       rdy_n,
  input logic       oe,
  input logic       irq,
  input logic       irq_req,
  input logic       pol
);
  AST_RESET_FOLLOWS_INPUT: assert property (@(posedge clk)
    !rst_async_n |-> rst_out); // R2

  AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (rst_out)
    $past(!rst_out) |-> $stable(strap_bits)); // R1

  AST_NO_START_ALONE: assert property (@(posedge clk) disable iff (rst_out)
    (ce && st_bits == 2'd0 && (ads_n || cs_n)) |=> st_bits == 2'd0); // R3

  AST_READY_WITH_DATA: assert property (@(posedge clk) disable iff (rst_out)
    (strap_bits[4] && $rose(oe)) |-> !rdy_n); // R5

  AST_READY_AHEAD: assert property (@(posedge clk) disable iff (rst_out)
    (!strap_bits[4] && $rose(oe) && $past(!cs_n)) |-> (rdy_n && $past(!rdy_n))); // R6

  AST_HALF_RATE_TICK: assert property (@(posedge clk) disable iff (rst_out)
    (strap_bits[0] && $past(!rst_out)) |-> ce != $past(ce)); // R7

  AST_IRQ_HIGH_POL: assert property (@(posedge clk) disable iff (rst_out)
    ($past(!rst_out) && $past(pol)) |-> irq == $past(irq_req)); // R11

  AST_IRQ_LOW_POL: assert property (@(posedge clk) disable iff (rst_out)
    ($past(!rst_out) && $past(!pol)) |-> irq == !$past(irq_req)); // R11
endmodule

bind mgmt_bus_port mbp_checker u_chk (
  .clk(clk), .rst_async_n(rst_async_n), .rst_out(rst_out),
  .strap_bits(strap_bits), .st_bits(st_bits), .ce(ce),
  .ads_n(ads_n), .cs_n(cs_n), .rdy_n(rdy_n), .oe(bus_rdata_oe),
  .irq(irq), .irq_req(irq_req), .pol(irq_pol)
);

// File: tb/mgmt_bus_port_tb.sv
module mgmt_bus_port_tb;
  logic        clk = 1'b0;
  logic        rst_async_n = 1'b0;
  logic [4:0]  strap_cfg = 5'b0;
  logic        irq_req = 1'b0;
  logic [11:1] bus_addr = '0;
  logic        ads_n = 1'b1, cs_n = 1'b1, rwc = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rdata_oe, rdy_n, bs16_n, irq, rst_out;

  always #4 clk = ~clk;

  mgmt_bus_port u_dut (
    .clk(clk), .rst_async_n(rst_async_n), .strap_cfg(strap_cfg), .irq_req(irq_req),
    .bus_addr(bus_addr), .ads_n(ads_n), .cs_n(cs_n), .rwc(rwc), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .rdy_n(rdy_n), .bs16_n(bs16_n),
    .irq(irq), .rst_out(rst_out)
  );

  int n_run = 0, n_fail = 0;
  logic [4:0]  cur = 5'b0;
  logic [15:0] mdl [16];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        prev_oe = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] swp(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  function automatic logic [31:0] place(input logic [11:1] a, input logic [15:0] w,
                                        input logic [15:0] other);
    if (cur[3] && a[1]) return {w, other};
    return {other, w};
  endfunction

  // Scoreboard monitor: compares each data window against the queued expectation
  always @(negedge clk) begin
    if (bus_rdata_oe && !prev_oe) begin
      if (exp_q.size() == 0) chk(1'b0, "R13", "unexpected read data", bus_rdata, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata == e, t, "read data", bus_rdata, e);
      end
    end
    prev_oe = bus_rdata_oe;
  end

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk);
    rst_async_n = 1'b0; strap_cfg = s; ads_n = 1'b1; cs_n = 1'b1;
    #1 chk(rst_out == 1'b1, "R2", "reset output on assertion", rst_out, 1);
    repeat (3) @(negedge clk);
    chk(rdy_n && !bus_rdata_oe && irq, "R2", "outputs idle in reset",
        {rdy_n, bus_rdata_oe, irq}, 3'b101);
    rst_async_n = 1'b1;
    @(negedge clk);
    chk(rst_out == 1'b1, "R2", "reset held one edge", rst_out, 1);
    @(negedge clk);
    chk(rst_out == 1'b0, "R2", "reset released second edge", rst_out, 0);
    chk(bs16_n == 1'b0, "R10", "bus size 16", bs16_n, 0);
    cur = s;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_op(input logic [11:1] a, input bit rd, input logic [31:0] wd,
                        input string req);
    int tl, rf, rc, of, oc;
    tl = cur[0] ? 2 : 1;
    rf = -1; of = -1; rc = 0; oc = 0;
    bus_addr = a; bus_wdata = wd; rwc = cur[2] ? ~rd : rd;
    ads_n = 1'b0; cs_n = 1'b0;
    for (int k = 0; k < 8 * tl; k++) begin
      @(negedge clk);
      if (k == tl - 1) ads_n = 1'b1;
      if (!rdy_n) begin if (rf < 0) rf = k; rc++; end
      if (bus_rdata_oe) begin if (of < 0) of = k; oc++; end
      chk(bs16_n == 1'b0, "R10", "bus size 16", bs16_n, 0);
    end
    cs_n = 1'b1;
    chk(rc == tl, req, "ready length", rc, tl);
    chk(oc == (rd ? tl : 0), req, "data window length", oc, rd ? tl : 0);
    if (tl == 1) chk(rf == (cur[4] ? 1 : 0), req, "ready position", rf, cur[4] ? 1 : 0);
    if (rd) chk(of == (cur[4] ? rf : rf + tl), req, "data vs ready", of, cur[4] ? rf : rf + tl);
  endtask

  task automatic wr(input logic [11:1] a, input logic [15:0] w, input string req);
    bus_op(a, 1'b0, place(a, w, 16'hEEEE), req);
    if (a[11:5] == '0) mdl[a[4:1]] = cur[1] ? swp(w) : w;
  endtask

  task automatic rd(input logic [11:1] a, input string req);
    logic [15:0] w;
    w = (a[11:5] == '0) ? (cur[1] ? swp(mdl[a[4:1]]) : mdl[a[4:1]]) : 16'h0;
    exp_q.push_back(place(a, w, 16'h0));
    tag_q.push_back(req);
    bus_op(a, 1'b1, 32'h0, req);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // Early ready, 1X, little endian, 16-bit bus
    do_reset(5'b00000);
    wr(11'd2, 16'h1234, "R13");
    rd(11'd2, "R6");
    // R1: strap inputs change after reset; behaviour must not follow
    strap_cfg = 5'b11111;
    rd(11'd2, "R1");

    // Normal ready timing and address decode
    do_reset(5'b10000);
    wr(11'd3, 16'h00FF, "R5");
    rd(11'd3, "R5");
    wr(11'd1, 16'h2222, "R13");
    wr(11'h401, 16'h7777, "R13");
    rd(11'd1, "R13");
    rd(11'h400, "R13");

    // R4: inverted read/write control
    do_reset(5'b10100);
    wr(11'd4, 16'hBEEF, "R4");
    rd(11'd4, "R4");

    // R8: big endian write, then little endian read after reset
    do_reset(5'b10010);
    wr(11'd5, 16'hABCD, "R8");
    rd(11'd5, "R8");
    do_reset(5'b10000);
    rd(11'd5, "R8");

    // R9: 32-bit bus lane selection
    do_reset(5'b11000);
    wr(11'd7, 16'h5A5A, "R9");
    rd(11'd7, "R9");
    wr(11'd8, 16'h0F0F, "R9");
    rd(11'd8, "R9");

    // R7: 2X clock, both ready timings
    do_reset(5'b10001);
    wr(11'd9, 16'h1357, "R7");
    rd(11'd9, "R7");
    do_reset(5'b00001);
    rd(11'd9, "R7");

    // R3: strobe without select, select without strobe
    do_reset(5'b10000);
    wr(11'd10, 16'h4444, "R3");
    bus_addr = 11'd10; bus_wdata = 32'h0000_9999; rwc = 1'b0;
    ads_n = 1'b0; cs_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(rdy_n == 1'b1, "R3", "no ready on strobe alone", rdy_n, 1);
    end
    ads_n = 1'b1; cs_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(rdy_n == 1'b1, "R3", "no ready on select alone", rdy_n, 1);
    end
    cs_n = 1'b1;
    @(negedge clk);
    rd(11'd10, "R3");

    // R12: select withdrawn right after the strobe is captured
    bus_addr = 11'd10; rwc = 1'b1; ads_n = 1'b0; cs_n = 1'b0;
    @(negedge clk);
    ads_n = 1'b1; cs_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(rdy_n && !bus_rdata_oe, "R12", "outputs quiet without select",
          {rdy_n, bus_rdata_oe}, 2'b10);
    end
    rd(11'd10, "R12");

    // R11: interrupt polarity
    irq_req = 1'b1;
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R11", "default active-low irq", irq, 0);
    wr(11'd0, 16'h0001, "R11");
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R11", "active-high irq asserted", irq, 1);
    irq_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R11", "active-high irq released", irq, 0);

    chk(exp_q.size() == 0, "R13", "all reads answered", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule